// File: doc/BRIEF.md
# Multiplexed Address/Data Link

This block pairs a requesting end and a responding end joined by a narrow shared bus. Address and data travel on the same lines at different times. Each transaction starts with an address phase, during which both ends capture the address. Data beats follow on the same lines. A command can move a single word, or a block of up to sixteen words. A block sends its start address only once, and the responder then steps through consecutive word addresses by itself.

The bus has two lane groups, each `LW` bits wide. The address/data lanes carry the address and then the data. The extension lanes carry a small header during the first address beat: a wide flag in bit 4 and the word count minus one in bits 3:0. In a wide block, the extension lanes also carry data, so each beat moves twice as many bits. With the default 16-bit lanes, a 32-bit address takes two beats. A 32-bit word takes two beats in narrow mode and one beat in wide mode. Reads insert one idle cycle, in which nothing drives the bus, before the responder starts sending data.

On the requesting side the block has a command port, a write-word source that it pops, and a read-word output. On the responding side it has a memory-style port with a combinational read. The shared bus is also brought out as outputs so that it can be observed.

Top module: `adm_link`

## Requirements
- R1: On the cycle after a command is accepted, `bus_ale` goes high for AW/LW cycles. `bus_ad` carries the address low piece first. `bus_rw` is 1 for a read and 0 for a write. In the first address cycle `bus_ext[4]` is the wide flag, `bus_ext[3:0]` is the word count minus one, and all other bits are 0. In later address cycles `bus_ext` is 0.
- R2: The responder assembles the full address from the address beats, and its first memory access (`mem_addr`) uses exactly that address.
- R3: `bus_ale` and `bus_ds` are never high in the same cycle. Data beats start only after the last address beat.
- R4: A read has exactly one cycle after the address phase in which `bus_ale` and `bus_ds` are low and `bus_ad` and `bus_ext` are zero. The two ends never drive the bus in the same cycle. A write has no such gap.
- R5: Within a block, word k is accessed at the start address plus k, with no further address phase.
- R6: `bus_last` is high only on the final beat of the final word. A block carries exactly count+1 words, from 1 to 16.
- R7: In a wide block, each beat carries the word's lower half on `bus_ad` and its upper half on `bus_ext`, so a 32-bit word takes one beat.
- R8: In narrow mode, a word takes DW/LW beats on `bus_ad`, lowest piece first, and `bus_ext` is 0. `mem_we` pulses only on the final beat of each word, with the complete word on `mem_wdata`.
- R9: `cmd_ready` is high only while idle. `cmd_done` pulses for one cycle, the cycle after the final data beat.
- R10: For reads, `rd_valid` pulses the cycle after the final beat of each word, with the word on `rd_data` in order. `rd_last` marks the final word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Requester idle, command accepted |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | AW | Start word address |
| cmd_len | input | 4 | Words minus one |
| cmd_wide | input | 1 | Use extension lanes for data |
| wd_data | input | DW | Current write word |
| wd_pop | output | 1 | Write word consumed this cycle |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DW | Read word |
| rd_last | output | 1 | Final read word |
| cmd_done | output | 1 | Transaction finished |
| mem_addr | output | AW | Responder word address |
| mem_we | output | 1 | Responder write strobe |
| mem_re | output | 1 | Responder read in progress |
| mem_wdata | output | DW | Responder write word |
| mem_rdata | input | DW | Responder read word (combinational) |
| bus_ale | output | 1 | Address-valid strobe |
| bus_ds | output | 1 | Data strobe |
| bus_rw | output | 1 | Direction, 1 = read |
| bus_last | output | 1 | Final beat marker |
| bus_ad | output | LW | Address/data lanes |
| bus_ext | output | LW | Extension lanes (header or data) |

## Verification
Both ends count pieces in lockstep and only communicate through the strobes. A wrong piece counter or a wrong captured header therefore appears within one beat: as a misplaced half-word on `bus_ad`, a `mem_we` on the wrong beat, or a `bus_last` at the wrong position. A wrong address latch shows up on `mem_addr` in the first data cycle. A slip in the word stepping shows up on the next word's `mem_addr`. The bench compares every bus cycle of each transaction against values it computes from the command, so such faults appear in the cycle they occur.

// File: rtl/adm_pkg.sv
package adm_pkg;
   localparam int HDR_LEN_W = 4;
   localparam int HDR_W     = HDR_LEN_W + 1;

   typedef enum logic [2:0] {
      M_IDLE, M_ADDR, M_TURN, M_WR, M_RD
   } mst_e;

   typedef enum logic [2:0] {
      S_IDLE, S_TURN, S_WR, S_RD
   } slv_e;
endpackage

// File: rtl/adm_bus_merge.sv
module adm_bus_merge #(
   parameter int LW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          m_oe,
   input  logic          m_ale,
   input  logic          m_ds,
   input  logic          m_rw,
   input  logic          m_last,
   input  logic [LW-1:0] m_ad,
   input  logic [LW-1:0] m_ext,
   input  logic          s_oe,
   input  logic          s_ds,
   input  logic          s_last,
   input  logic [LW-1:0] s_ad,
   input  logic [LW-1:0] s_ext,
   output logic          b_ale,
   output logic          b_ds,
   output logic          b_rw,
   output logic          b_last,
   output logic [LW-1:0] b_ad,
   output logic [LW-1:0] b_ext
);
   assign b_ale  = m_ale;
   assign b_rw   = m_rw;
   assign b_ds   = (m_oe & m_ds) | (s_oe & s_ds);
   assign b_last = (m_oe & m_last) | (s_oe & s_last);
   assign b_ad   = m_oe ? m_ad  : (s_oe ? s_ad  : '0);
   assign b_ext  = m_oe ? m_ext : (s_oe ? s_ext : '0);

   // R4
   one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_oe && s_oe));
   // R3
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(b_ale && b_ds));
endmodule

// File: rtl/adm_master.sv
module adm_master
   import adm_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int LW      = 16,
   parameter int WIDE_EN = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic                 cmd_read,
   input  logic [AW-1:0]        cmd_addr,
   input  logic [HDR_LEN_W-1:0] cmd_len,
   input  logic                 cmd_wide,
   input  logic [DW-1:0]        wd_data,
   output logic                 wd_pop,
   output logic                 rd_valid,
   output logic [DW-1:0]        rd_data,
   output logic                 rd_last,
   output logic                 cmd_done,
   output logic                 m_oe,
   output logic                 m_ale,
   output logic                 m_ds,
   output logic                 m_rw,
   output logic                 m_last,
   output logic [LW-1:0]        m_ad,
   output logic [LW-1:0]        m_ext,
   input  logic                 b_ds,
   input  logic                 b_last,
   input  logic [LW-1:0]        b_ad,
   input  logic [LW-1:0]        b_ext
);
   localparam int   APC     = AW / LW;
   localparam int   UPW     = DW / LW;
   localparam int   AC_W    = $clog2(APC) + 1;
   localparam int   UC_W    = $clog2(UPW) + 2;
   localparam logic WIDE_OK = (WIDE_EN != 0);

   generate
      if (AW % LW != 0) begin : g_bad_aw
         $error("adm_master: AW must be a multiple of LW");
      end
      if (DW % LW != 0) begin : g_bad_dw
         $error("adm_master: DW must be a multiple of LW");
      end
      if (WIDE_EN != 0 && (UPW % 2) != 0) begin : g_bad_wide
         $error("adm_master: wide mode needs an even piece count");
      end
      if (LW < HDR_W) begin : g_bad_hdr
         $error("adm_master: lanes too narrow for header");
      end
   endgenerate

   function automatic logic [DW-1:0] put_w(input logic [DW-1:0] w, input int idx,
                                           input logic [LW-1:0] v);
      logic [DW-1:0] m;
      m = DW'({LW{1'b1}}) << (idx * LW);
      return (w & ~m) | (DW'(v) << (idx * LW));
   endfunction

   mst_e                 st;
   logic [AC_W-1:0]      apc;
   logic [UC_W-1:0]      up;
   logic [HDR_LEN_W-1:0] wcnt, a_len;
   logic [AW-1:0]        a_addr;
   logic                 a_read, a_wide;
   logic [DW-1:0]        rhold, merged;
   logic                 done_q, rv_q, rl_q;
   logic [DW-1:0]        rd_q;
   logic                 wide_eff, eow, fin;
   logic [UC_W-1:0]      step;

   assign wide_eff = a_wide & WIDE_OK;
   assign step     = wide_eff ? UC_W'(2) : UC_W'(1);
   assign eow      = (up + step) == UC_W'(UPW);
   assign fin      = eow && (wcnt == a_len);

   always_comb begin
      merged = put_w(rhold, int'(up), b_ad);
      if (wide_eff) merged = put_w(merged, int'(up) + 1, b_ext);
   end

   assign cmd_ready = (st == M_IDLE);
   assign m_oe      = (st == M_ADDR) || (st == M_WR);
   assign m_ale     = (st == M_ADDR);
   assign m_ds      = (st == M_WR);
   assign m_rw      = a_read;
   assign m_last    = (st == M_WR) && fin;
   assign wd_pop    = (st == M_WR) && eow;

   always_comb begin
      m_ad  = '0;
      m_ext = '0;
      if (st == M_ADDR) begin
         m_ad = LW'(a_addr >> (int'(apc) * LW));
         if (apc == '0) m_ext = LW'({wide_eff, a_len});
      end else if (st == M_WR) begin
         m_ad = LW'(wd_data >> (int'(up) * LW));
         if (wide_eff) m_ext = LW'(wd_data >> ((int'(up) + 1) * LW));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= M_IDLE;
         apc    <= '0;
         up     <= '0;
         wcnt   <= '0;
         a_len  <= '0;
         a_addr <= '0;
         a_read <= 1'b0;
         a_wide <= 1'b0;
         rhold  <= '0;
         done_q <= 1'b0;
         rv_q   <= 1'b0;
         rl_q   <= 1'b0;
         rd_q   <= '0;
      end else begin
         done_q <= 1'b0;
         rv_q   <= 1'b0;
         case (st)
            M_IDLE: if (cmd_valid) begin
               st     <= M_ADDR;
               a_addr <= cmd_addr;
               a_len  <= cmd_len;
               a_read <= cmd_read;
               a_wide <= cmd_wide;
               apc    <= '0;
               up     <= '0;
               wcnt   <= '0;
            end
            M_ADDR: begin
               if (apc == AC_W'(APC - 1)) st <= a_read ? M_TURN : M_WR;
               else                       apc <= apc + 1'b1;
            end
            M_TURN: st <= M_RD;
            M_WR: begin
               if (eow) begin
                  up   <= '0;
                  wcnt <= wcnt + 1'b1;
                  if (fin) begin
                     st     <= M_IDLE;
                     done_q <= 1'b1;
                  end
               end else begin
                  up <= up + step;
               end
            end
            M_RD: if (b_ds) begin
               rhold <= merged;
               if (eow) begin
                  up   <= '0;
                  rv_q <= 1'b1;
                  rd_q <= merged;
                  rl_q <= b_last;
                  if (b_last) begin
                     st     <= M_IDLE;
                     done_q <= 1'b1;
                  end
               end else begin
                  up <= up + step;
               end
            end
            default: st <= M_IDLE;
         endcase
      end
   end

   assign cmd_done = done_q;
   assign rd_valid = rv_q;
   assign rd_data  = rd_q;
   assign rd_last  = rl_q;

   // R4
   turn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == M_TURN) |-> !b_ds);
   // R9
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == M_RD && b_ds && b_last) |=> (cmd_done && cmd_ready));
endmodule

// File: rtl/adm_slave.sv
module adm_slave
   import adm_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int LW      = 16,
   parameter int WIDE_EN = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          b_ale,
   input  logic          b_ds,
   input  logic          b_rw,
   input  logic          b_last,
   input  logic [LW-1:0] b_ad,
   input  logic [LW-1:0] b_ext,
   output logic          s_oe,
   output logic          s_ds,
   output logic          s_last,
   output logic [LW-1:0] s_ad,
   output logic [LW-1:0] s_ext,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic          mem_re,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   localparam int   APC     = AW / LW;
   localparam int   UPW     = DW / LW;
   localparam int   AC_W    = $clog2(APC) + 1;
   localparam int   UC_W    = $clog2(UPW) + 2;
   localparam logic WIDE_OK = (WIDE_EN != 0);

   function automatic logic [AW-1:0] put_a(input logic [AW-1:0] w, input int idx,
                                           input logic [LW-1:0] v);
      logic [AW-1:0] m;
      m = AW'({LW{1'b1}}) << (idx * LW);
      return (w & ~m) | (AW'(v) << (idx * LW));
   endfunction

   function automatic logic [DW-1:0] put_w(input logic [DW-1:0] w, input int idx,
                                           input logic [LW-1:0] v);
      logic [DW-1:0] m;
      m = DW'({LW{1'b1}}) << (idx * LW);
      return (w & ~m) | (DW'(v) << (idx * LW));
   endfunction

   slv_e                 st;
   logic [AC_W-1:0]      apc;
   logic [UC_W-1:0]      up;
   logic [HDR_LEN_W-1:0] wcnt, s_len;
   logic                 s_wide;
   logic [AW-1:0]        s_addr;
   logic [DW-1:0]        whold, merged;
   logic                 wide_eff, eow, fin;
   logic [UC_W-1:0]      step;

   assign wide_eff = s_wide & WIDE_OK;
   assign step     = wide_eff ? UC_W'(2) : UC_W'(1);
   assign eow      = (up + step) == UC_W'(UPW);
   assign fin      = eow && (wcnt == s_len);

   always_comb begin
      merged = put_w(whold, int'(up), b_ad);
      if (wide_eff) merged = put_w(merged, int'(up) + 1, b_ext);
   end

   assign s_oe      = (st == S_RD);
   assign s_ds      = (st == S_RD);
   assign s_last    = (st == S_RD) && fin;
   assign s_ad      = LW'(mem_rdata >> (int'(up) * LW));
   assign s_ext     = wide_eff ? LW'(mem_rdata >> ((int'(up) + 1) * LW)) : '0;
   assign mem_addr  = s_addr;
   assign mem_re    = (st == S_RD);
   assign mem_we    = (st == S_WR) && b_ds && eow;
   assign mem_wdata = merged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         apc    <= '0;
         up     <= '0;
         wcnt   <= '0;
         s_len  <= '0;
         s_wide <= 1'b0;
         s_addr <= '0;
         whold  <= '0;
      end else begin
         case (st)
            S_IDLE: if (b_ale) begin
               s_addr <= put_a(s_addr, int'(apc), b_ad);
               if (apc == '0) begin
                  s_wide <= b_ext[HDR_LEN_W];
                  s_len  <= b_ext[HDR_LEN_W-1:0];
               end
               if (apc == AC_W'(APC - 1)) begin
                  apc  <= '0;
                  up   <= '0;
                  wcnt <= '0;
                  st   <= b_rw ? S_TURN : S_WR;
               end else begin
                  apc <= apc + 1'b1;
               end
            end
            S_TURN: st <= S_RD;
            S_RD: begin
               if (eow) begin
                  up     <= '0;
                  wcnt   <= wcnt + 1'b1;
                  s_addr <= s_addr + 1'b1;
                  if (fin) st <= S_IDLE;
               end else begin
                  up <= up + step;
               end
            end
            S_WR: if (b_ds) begin
               whold <= merged;
               if (eow) begin
                  up     <= '0;
                  s_addr <= s_addr + 1'b1;
               end else begin
                  up <= up + step;
               end
               if (b_last) st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R3
   addr_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_ale |-> (st == S_IDLE));
   // R6
   last_on_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WR && b_ds && b_last) |-> eow);
endmodule

// File: rtl/adm_link.sv
module adm_link
   import adm_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int LW      = 16,
   parameter int WIDE_EN = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic                 cmd_read,
   input  logic [AW-1:0]        cmd_addr,
   input  logic [HDR_LEN_W-1:0] cmd_len,
   input  logic                 cmd_wide,
   input  logic [DW-1:0]        wd_data,
   output logic                 wd_pop,
   output logic                 rd_valid,
   output logic [DW-1:0]        rd_data,
   output logic                 rd_last,
   output logic                 cmd_done,
   output logic [AW-1:0]        mem_addr,
   output logic                 mem_we,
   output logic                 mem_re,
   output logic [DW-1:0]        mem_wdata,
   input  logic [DW-1:0]        mem_rdata,
   output logic                 bus_ale,
   output logic                 bus_ds,
   output logic                 bus_rw,
   output logic                 bus_last,
   output logic [LW-1:0]        bus_ad,
   output logic [LW-1:0]        bus_ext
);
   logic          m_oe, m_ale, m_ds, m_rw, m_last;
   logic [LW-1:0] m_ad, m_ext;
   logic          s_oe, s_ds, s_last;
   logic [LW-1:0] s_ad, s_ext;

   adm_master #(.AW(AW), .DW(DW), .LW(LW), .WIDE_EN(WIDE_EN)) u_mst (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wide(cmd_wide),
      .wd_data(wd_data), .wd_pop(wd_pop),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last), .cmd_done(cmd_done),
      .m_oe(m_oe), .m_ale(m_ale), .m_ds(m_ds), .m_rw(m_rw), .m_last(m_last),
      .m_ad(m_ad), .m_ext(m_ext),
      .b_ds(bus_ds), .b_last(bus_last), .b_ad(bus_ad), .b_ext(bus_ext)
   );

   adm_slave #(.AW(AW), .DW(DW), .LW(LW), .WIDE_EN(WIDE_EN)) u_slv (
      .clk(clk), .rst_n(rst_n),
      .b_ale(bus_ale), .b_ds(bus_ds), .b_rw(bus_rw), .b_last(bus_last),
      .b_ad(bus_ad), .b_ext(bus_ext),
      .s_oe(s_oe), .s_ds(s_ds), .s_last(s_last), .s_ad(s_ad), .s_ext(s_ext),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   adm_bus_merge #(.LW(LW)) u_bus (
      .clk(clk), .rst_n(rst_n),
      .m_oe(m_oe), .m_ale(m_ale), .m_ds(m_ds), .m_rw(m_rw), .m_last(m_last),
      .m_ad(m_ad), .m_ext(m_ext),
      .s_oe(s_oe), .s_ds(s_ds), .s_last(s_last), .s_ad(s_ad), .s_ext(s_ext),
      .b_ale(bus_ale), .b_ds(bus_ds), .b_rw(bus_rw), .b_last(bus_last),
      .b_ad(bus_ad), .b_ext(bus_ext)
   );
endmodule

// File: tb/adm_link_bench.sv
module adm_link_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_read = 1'b0, cmd_wide = 1'b0;
   logic [31:0] cmd_addr = '0;
   logic [3:0]  cmd_len = '0;
   logic [31:0] wd_data, rd_data, mem_addr, mem_wdata, mem_rdata;
   logic        cmd_ready, wd_pop, rd_valid, rd_last, cmd_done, mem_we, mem_re;
   logic        bus_ale, bus_ds, bus_rw, bus_last;
   logic [15:0] bus_ad, bus_ext;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   logic [31:0] src [64];
   logic [31:0] mem [64];
   logic [31:0] exp_mem [64];
   logic [5:0]  widx = '0;

   always #10 clk = ~clk;

   adm_link u_adm_link (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wide(cmd_wide),
      .wd_data(wd_data), .wd_pop(wd_pop),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last), .cmd_done(cmd_done),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .bus_ale(bus_ale), .bus_ds(bus_ds), .bus_rw(bus_rw), .bus_last(bus_last),
      .bus_ad(bus_ad), .bus_ext(bus_ext)
   );

   function automatic logic [31:0] pat(input int i);
      return 32'h6B00_0000 ^ (i * 32'h0001_0203);
   endfunction

   assign wd_data   = src[widx];
   assign mem_rdata = mem[mem_addr[5:0]];

   always @(posedge clk) if (wd_pop) widx <= widx + 6'd1;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= pat(i);
      end else if (mem_we) begin
         mem[mem_addr[5:0]] <= mem_wdata;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic rd, input logic [31:0] a, input logic [3:0] l, input logic w);
      @(negedge clk);
      chk("R9 ready before command", 64'(cmd_ready), 64'd1);
      cmd_valid = 1'b1; cmd_read = rd; cmd_addr = a; cmd_len = l; cmd_wide = w;
      @(negedge clk);
      cmd_valid = 1'b0;
      // address phase, first beat
      chk("R1 ale beat0", 64'({bus_ale, bus_ds, bus_rw}), 64'({1'b1, 1'b0, rd}));
      chk("R1 addr low", 64'(bus_ad), 64'(a[15:0]));
      chk("R1 header", 64'(bus_ext), 64'({w, l}));
      chk("R9 ready busy", 64'(cmd_ready), 64'd0);
      @(negedge clk);
      chk("R1 ale beat1", 64'({bus_ale, bus_ds}), 64'b10);
      chk("R1 addr high", 64'(bus_ad), 64'(a[31:16]));
      chk("R1 ext zero", 64'(bus_ext), 64'd0);
   endtask

   task automatic do_write(input logic [31:0] a, input logic [3:0] l, input logic w);
      int bpw = w ? 1 : 2;
      int nb  = (int'(l) + 1) * bpw;
      logic [31:0] words [16];
      for (int k = 0; k <= int'(l); k++) begin
         words[k] = {a[7:0] + 8'(k), 8'hC3 ^ 8'(k * 7), 8'(k) << 2, 8'h5A ^ 8'(k)};
         src[6'(int'(widx) + k)] = words[k];
      end
      issue(1'b0, a, l, w);
      for (int b = 0; b < nb; b++) begin
         int wi = b / bpw;
         int u  = b % bpw;
         logic [15:0] ead, eext;
         ead  = w ? words[wi][15:0] : (u == 1 ? words[wi][31:16] : words[wi][15:0]);
         eext = w ? words[wi][31:16] : 16'h0;
         @(negedge clk);
         chk("R3 data beat strobes", 64'({bus_ale, bus_ds}), 64'b01);
         chk(w ? "R7 wide ad" : "R8 narrow ad", 64'(bus_ad), 64'(ead));
         chk(w ? "R7 wide ext" : "R8 narrow ext", 64'(bus_ext), 64'(eext));
         chk("R6 last position", 64'(bus_last), 64'(b == nb - 1));
         if (u == bpw - 1) begin
            chk("R8 write strobe", 64'(mem_we), 64'd1);
            chk(wi == 0 ? "R2 first address" : "R5 step address", 64'(mem_addr), 64'(a + wi));
            chk("R8 write word", 64'(mem_wdata), 64'(words[wi]));
            exp_mem[6'(a + wi)] = words[wi];
         end else begin
            chk("R8 no early strobe", 64'(mem_we), 64'd0);
         end
      end
      @(negedge clk);
      chk("R9 done pulse", 64'({cmd_done, cmd_ready}), 64'b11);
      chk("R6 bus quiet after", 64'({bus_ds, bus_last}), 64'b00);
      @(negedge clk);
      chk("R9 done single cycle", 64'(cmd_done), 64'd0);
   endtask

   task automatic do_read(input logic [31:0] a, input logic [3:0] l, input logic w);
      int bpw = w ? 1 : 2;
      int nb  = (int'(l) + 1) * bpw;
      bit pend = 0;
      logic [31:0] pword = '0;
      issue(1'b1, a, l, w);
      @(negedge clk);
      chk("R4 turnaround strobes", 64'({bus_ale, bus_ds}), 64'b00);
      chk("R4 turnaround lanes", 64'({bus_ad, bus_ext}), 64'd0);
      for (int b = 0; b < nb; b++) begin
         int wi = b / bpw;
         int u  = b % bpw;
         logic [31:0] ew;
         logic [15:0] ead, eext;
         ew   = exp_mem[6'(a + wi)];
         ead  = w ? ew[15:0] : (u == 1 ? ew[31:16] : ew[15:0]);
         eext = w ? ew[31:16] : 16'h0;
         @(negedge clk);
         chk("R3 read beat strobes", 64'({bus_ale, bus_ds}), 64'b01);
         chk(wi == 0 ? "R2 read address" : "R5 read step", 64'(mem_addr), 64'(a + wi));
         chk(w ? "R7 wide read ad" : "R8 narrow read ad", 64'(bus_ad), 64'(ead));
         chk(w ? "R7 wide read ext" : "R8 narrow read ext", 64'(bus_ext), 64'(eext));
         chk("R6 read last", 64'(bus_last), 64'(b == nb - 1));
         chk("R10 rd_valid timing", 64'(rd_valid), 64'(pend));
         if (pend) chk("R10 rd_data", 64'(rd_data), 64'(pword));
         pend = (u == bpw - 1);
         pword = ew;
      end
      @(negedge clk);
      chk("R10 final word valid", 64'({rd_valid, rd_last}), 64'b11);
      chk("R10 final word data", 64'(rd_data), 64'(pword));
      chk("R9 read done", 64'({cmd_done, cmd_ready}), 64'b11);
      @(negedge clk);
      chk("R10 valid drops", 64'(rd_valid), 64'd0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) exp_mem[i] = pat(i);
      for (int i = 0; i < 64; i++) src[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset ready", 64'({cmd_ready, cmd_done}), 64'b10);
      chk("R1 reset bus idle", 64'({bus_ale, bus_ds, bus_last}), 64'b000);
      chk("R10 reset read idle", 64'(rd_valid), 64'd0);
      chk("R8 reset no write", 64'(mem_we), 64'd0);

      do_write(32'hA5A5_0010, 4'd0, 1'b0);
      do_read (32'hA5A5_0010, 4'd0, 1'b0);
      do_write(32'h0003_0020, 4'd3, 1'b0);
      do_read (32'h0003_0020, 4'd3, 1'b0);
      do_write(32'h0000_0028, 4'd15, 1'b1);
      do_read (32'h0000_0028, 4'd15, 1'b1);
      do_read (32'h1234_0038, 4'd1, 1'b0);
      do_write(32'h0000_0004, 4'd0, 1'b1);
      do_read (32'h0000_0004, 4'd0, 1'b1);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule